// File: doc/BRIEF.md
# Serial Configuration Port with Pin-Strapped Start-Up

This block holds the four 22-bit control words of a radio transceiver's configuration logic. It is filled from a three-wire link made of a serial clock, a serial data line and a load enable. The link is oversampled in the system clock domain. Each rising edge of the serial clock shifts one data bit into a 24-bit register, most significant bit first. A rising edge of the load enable then moves the low 22 bits into the word chosen by the top two bits.

After reset the block runs in a pin-strapped fixed-frequency mode. Two strap pins pick one of four channels, and the four words track the default contents of that channel. In this mode the serial clock and data pins are read as receive-enable and transmit-enable levels that set the operating mode. The first change of the load-enable pin after start-up moves the block into programmable mode. It stays there until the next reset, and from then on the mode comes from word A.

The control is a four-state machine. WAKE lasts until the synchronizers hold settled pin levels. At its end the level of the enable pin is kept as a baseline. WAKE goes to STRAP once that time has passed. STRAP goes to PROG when the enable pin differs from the baseline. PROG goes to COMMIT on a rising edge of the enable pin. COMMIT writes the addressed word and always returns to PROG.

Top module: `cfg_serial_port`

## Requirements
- R1: In fixed mode the four words hold the defaults of channel {fs1,fs0}. Index 0 is 868.3 MHz with ratios 16/1919/1943, index 1 is 433.92 MHz with 16/947/971, index 2 is 915 MHz with 30/3794/3839, and index 3 is 315 MHz with 18/766/793. These are the reference ratio, the receive feedback ratio and the transmit feedback ratio. Word A is bits 15:12 set plus the reference ratio in bits 9:0. Word B is bits 19,18,15,14,13,11,10 set plus the reference ratio in bits 9:0. Word C is bit 18 set, bit 17 set for indices 1 and 3, and the receive ratio in bits 16:0. Word D is bit 20 set plus the transmit ratio in bits 16:0.
- R2: In fixed mode op_mode_o equals {transmit-enable pin, receive-enable pin}. The codes are 0 standby, 1 receive, 2 transmit and 3 idle.
- R3: In programmable mode each rising serial-clock edge shifts the data bit in, most significant bit first. Only the last 24 bits are kept, so any extra leading bits are dropped.
- R4: A rising load-enable edge in programmable mode writes bits 21:0 of the shift register into the word selected by bits 23:22. The codes are 0 for A, 1 for B, 2 for C and 3 for D.
- R5: A write leaves the other three words unchanged.
- R6: The first change of the enable pin after reset sets prog_mode_o, which stays set until reset. That edge loads nothing, whichever direction it goes.
- R7: In programmable mode op_mode_o equals word A bits 11:10, with the same codes as R2.
- R8: Serial-clock edges in fixed mode shift nothing. The shift register starts at zero, so a load with no bits sent writes zero into word A.
- R9: In programmable mode changes on the fs1 pin do not alter any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_re_i | input | 1 | Serial clock, or receive enable in fixed mode |
| sdat_te_i | input | 1 | Serial data, or transmit enable in fixed mode |
| sen_fs0_i | input | 1 | Load enable, or channel strap bit 0 |
| fs1_i | input | 1 | Channel strap bit 1 |
| reg_a_o | output | 22 | Word A |
| reg_b_o | output | 22 | Word B |
| reg_c_o | output | 22 | Word C |
| reg_d_o | output | 22 | Word D |
| prog_mode_o | output | 1 | Programmable mode flag |
| op_mode_o | output | 2 | Operating mode code |

## Verification
The bench enters programmable mode from both strap levels of the enable pin. A design that treated the entry edge as a load would corrupt a word with stale shift contents. It sends words with up to seven extra leading bits; a design that kept the first 24 bits rather than the last would write the wrong word. It toggles the serial clock with data high while still strapped and then loads with no bits sent. A design that shifted in fixed mode would write a non-zero word A. Random words to random addresses check that no neighbouring word is disturbed and that the mode follows word A rather than the pins.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
    localparam int WORD_W   = 24;
    localparam int DATA_W   = 22;
    localparam int ADDR_W   = 2;
    localparam int NUM_REGS = 4;

    typedef enum logic [1:0] {
        ST_WAKE   = 2'd0,
        ST_STRAP  = 2'd1,
        ST_PROG   = 2'd2,
        ST_COMMIT = 2'd3
    } port_state_e;

    // Channel defaults: index = {fs1, fs0}
    function automatic logic [DATA_W-1:0] default_word(input logic [ADDR_W-1:0] sel,
                                                       input logic [1:0] chan);
        logic [DATA_W-1:0] w;
        logic [9:0]  ref_div;
        logic [16:0] fb_rx;
        logic [16:0] fb_tx;
        unique case (chan)
            2'd0: begin ref_div = 10'd16; fb_rx = 17'd1919; fb_tx = 17'd1943; end
            2'd1: begin ref_div = 10'd16; fb_rx = 17'd947;  fb_tx = 17'd971;  end
            2'd2: begin ref_div = 10'd30; fb_rx = 17'd3794; fb_tx = 17'd3839; end
            default: begin ref_div = 10'd18; fb_rx = 17'd766; fb_tx = 17'd793; end
        endcase
        w = '0;
        unique case (sel)
            2'd0: begin
                w[15:12] = 4'hF;
                w[9:0]   = ref_div;
            end
            2'd1: begin
                w[19:18] = 2'b11;
                w[15:13] = 3'b111;
                w[11:10] = 2'b11;
                w[9:0]   = ref_div;
            end
            2'd2: begin
                w[18]    = 1'b1;
                w[17]    = chan[0];
                w[16:0]  = fb_rx;
            end
            default: begin
                w[20]    = 1'b1;
                w[16:0]  = fb_tx;
            end
        endcase
        return w;
    endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[W-2:0], bit_in};
    end
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
    import cfg_serial_pkg::*;
#(
    parameter int N  = NUM_REGS,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 preset_en,
    input  logic [N-1:0][DW-1:0] preset_val,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    output logic [N-1:0][DW-1:0] q
);
    logic [DW-1:0] slot_q [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    slot_q[i] <= DW'(default_word(ADDR_W'(i), 2'b00));
                else if (preset_en)
                    slot_q[i] <= preset_val[i];
                else if (wr_en && (wr_addr == AW'(i)))
                    slot_q[i] <= wr_data;
            end
            assign q[i] = slot_q[i];
        end
    endgenerate
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfg_serial_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_re_i,
    input  logic              sdat_te_i,
    input  logic              sen_fs0_i,
    input  logic              fs1_i,
    output logic [DATA_W-1:0] reg_a_o,
    output logic [DATA_W-1:0] reg_b_o,
    output logic [DATA_W-1:0] reg_c_o,
    output logic [DATA_W-1:0] reg_d_o,
    output logic              prog_mode_o,
    output logic [1:0]        op_mode_o
);
    localparam int PIN_CLK  = 0;
    localparam int PIN_DAT  = 1;
    localparam int PIN_EN   = 2;
    localparam int PIN_FS1  = 3;
    localparam int NUM_PINS = 4;
    localparam int WAKE_CYC = SYNC_STAGES + 1;
    localparam int CNT_W    = $clog2(WAKE_CYC + 1);

    logic [NUM_PINS-1:0] pin_raw, pin_s;
    logic                clk_prev, en_prev, clk_rise, en_rise;
    logic                en_base;
    logic [CNT_W-1:0]    wake_cnt;
    port_state_e         state, state_nx;
    logic [WORD_W-1:0]   shreg;
    logic                in_prog, preset_en, shift_en, wr_en;
    logic [NUM_REGS-1:0][DATA_W-1:0] preset_val, lat_q;

    assign pin_raw = {fs1_i, sen_fs0_i, sdat_te_i, sclk_re_i};

    cfg_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d (pin_raw),
        .q (pin_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_prev <= 1'b0;
            en_prev  <= 1'b0;
        end else begin
            clk_prev <= pin_s[PIN_CLK];
            en_prev  <= pin_s[PIN_EN];
        end
    end
    assign clk_rise = pin_s[PIN_CLK] & ~clk_prev;
    assign en_rise  = pin_s[PIN_EN]  & ~en_prev;

    // Wake counter and strap baseline of the enable pin
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_cnt <= '0;
            en_base  <= 1'b0;
        end else if (state == ST_WAKE) begin
            wake_cnt <= wake_cnt + 1'b1;
            en_base  <= pin_s[PIN_EN];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAKE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAKE:   if (wake_cnt == CNT_W'(WAKE_CYC)) state_nx = ST_STRAP;
            ST_STRAP:  if (pin_s[PIN_EN] != en_base)     state_nx = ST_PROG;
            ST_PROG:   if (en_rise)                      state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_PROG;
            default:   state_nx = ST_WAKE;
        endcase
    end

    assign in_prog   = (state == ST_PROG) || (state == ST_COMMIT);
    assign preset_en = (state == ST_WAKE) || (state == ST_STRAP);
    assign shift_en  = in_prog && clk_rise;
    assign wr_en     = (state == ST_COMMIT);

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_preset
            assign preset_val[i] = default_word(ADDR_W'(i), {pin_s[PIN_FS1], en_base});
        end
    endgenerate

    cfg_shift #(.W(WORD_W)) i_shift (
        .clk (clk),
        .rst_n (rst_n),
        .shift_en (shift_en),
        .bit_in (pin_s[PIN_DAT]),
        .q (shreg)
    );

    cfg_latch_bank #(.N(NUM_REGS), .DW(DATA_W), .AW(ADDR_W)) i_bank (
        .clk (clk),
        .rst_n (rst_n),
        .preset_en (preset_en),
        .preset_val (preset_val),
        .wr_en (wr_en),
        .wr_addr (shreg[WORD_W-1 -: ADDR_W]),
        .wr_data (shreg[DATA_W-1:0]),
        .q (lat_q)
    );

    assign reg_a_o = lat_q[0];
    assign reg_b_o = lat_q[1];
    assign reg_c_o = lat_q[2];
    assign reg_d_o = lat_q[3];

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_mode_o <= 1'b0;
            op_mode_o   <= 2'b00;
        end else begin
            prog_mode_o <= in_prog;
            op_mode_o   <= in_prog ? lat_q[0][11:10]
                                   : {pin_s[PIN_DAT], pin_s[PIN_CLK]};
        end
    end
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [21:0] reg_a_o,
    input logic [21:0] reg_b_o,
    input logic [21:0] reg_c_o,
    input logic [21:0] reg_d_o,
    input logic        prog_mode_o,
    input logic [1:0]  op_mode_o
);
    // R6: programmable mode is never left without reset
    p_prog_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_mode_o |=> prog_mode_o);

    // R5: at most one word changes per cycle in programmable mode
    p_one_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_mode_o && $past(prog_mode_o)) |->
        ($countones({reg_a_o != $past(reg_a_o), reg_b_o != $past(reg_b_o),
                     reg_c_o != $past(reg_c_o), reg_d_o != $past(reg_d_o)}) <= 1));

    // R7: mode follows word A in programmable mode
    p_mode_from_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_mode_o |-> (op_mode_o == $past(reg_a_o[11:10])));

    // R1: strap defaults keep the mode field at standby and a non-zero transmit ratio
    p_strap_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_mode_o |-> ((reg_a_o[11:10] == 2'b00) && (reg_d_o[16:0] != 17'd0)));
endmodule

bind cfg_serial_port cfg_serial_port_chk i_chk (.*);

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_re = 1'b0, sdat_te = 1'b0, sen_fs0 = 1'b0, fs1 = 1'b0;
    logic [21:0] reg_a, reg_b, reg_c, reg_d;
    logic        prog_mode;
    logic [1:0]  op_mode;
    int          vectors = 0;
    int          fails = 0;
    bit          done = 1'b0;
    logic [21:0] model [4];

    always #5 clk = ~clk;

    cfg_serial_port i_cfg_serial_port (
        .clk (clk), .rst_n (rst_n),
        .sclk_re_i (sclk_re), .sdat_te_i (sdat_te),
        .sen_fs0_i (sen_fs0), .fs1_i (fs1),
        .reg_a_o (reg_a), .reg_b_o (reg_b), .reg_c_o (reg_c), .reg_d_o (reg_d),
        .prog_mode_o (prog_mode), .op_mode_o (op_mode)
    );

    function automatic logic [21:0] exp_def(int sel, int ch);
        int rref, nrx, ntx;
        logic [21:0] w;
        if (ch == 0)      begin rref = 16; nrx = 1919; ntx = 1943; end
        else if (ch == 1) begin rref = 16; nrx = 947;  ntx = 971;  end
        else if (ch == 2) begin rref = 30; nrx = 3794; ntx = 3839; end
        else              begin rref = 18; nrx = 766;  ntx = 793;  end
        if (sel == 0)      w = 22'h00F000 | 22'(rref);
        else if (sel == 1) w = 22'h0CEC00 | 22'(rref);
        else if (sel == 2) w = 22'h040000 | ((ch % 2 == 1) ? 22'h020000 : 22'h0) | 22'(nrx);
        else               w = 22'h100000 | 22'(ntx);
        return w;
    endfunction

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_words(string req);
        check(req, 32'(reg_a), 32'(model[0]));
        check(req, 32'(reg_b), 32'(model[1]));
        check(req, 32'(reg_c), 32'(model[2]));
        check(req, 32'(reg_d), 32'(model[3]));
    endtask

    task automatic load_defaults(int ch);
        for (int i = 0; i < 4; i++) model[i] = exp_def(i, ch);
    endtask

    task automatic do_reset(int ch);
        sen_fs0 = ch[0];
        fs1     = ch[1];
        sclk_re = 1'b0;
        sdat_te = 1'b0;
        rst_n   = 1'b0;
        wait_cyc(3);
        rst_n   = 1'b1;
        wait_cyc(10);
    endtask

    task automatic send_bit(logic b);
        sdat_te = b;
        wait_cyc(4);
        sclk_re = 1'b1;
        wait_cyc(4);
        sclk_re = 1'b0;
        wait_cyc(4);
    endtask

    task automatic send_word(logic [23:0] w, int extra);
        sen_fs0 = 1'b0;
        wait_cyc(6);
        for (int i = 0; i < extra; i++) send_bit(1'($urandom));
        for (int i = 23; i >= 0; i--) send_bit(w[i]);
        sen_fs0 = 1'b1;
        wait_cyc(10);
        model[w[23:22]] = w[21:0];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20417));

        // R1, R2: every strap channel and every pin mode
        for (int ch = 0; ch < 4; ch++) begin
            do_reset(ch);
            load_defaults(ch);
            check_words("R1");
            check("R6", 32'(prog_mode), 32'd0);
            for (int m = 0; m < 4; m++) begin
                sclk_re = m[0];
                sdat_te = m[1];
                wait_cyc(6);
                check("R2", 32'(op_mode), 32'(m));
            end
            // R8 stimulus: serial-clock edges with data high while strapped
            sdat_te = 1'b1;
            for (int k = 0; k < 5; k++) begin
                sclk_re = 1'b1; wait_cyc(4);
                sclk_re = 1'b0; wait_cyc(4);
            end
            sdat_te = 1'b0;
            wait_cyc(4);
            check_words("R1");
        end

        // Channel 3 strap has enable high: a falling edge enters programmable mode
        sen_fs0 = 1'b0;
        wait_cyc(8);
        check("R6", 32'(prog_mode), 32'd1);
        check_words("R6");
        // R8: load with no bits sent writes zero into word A
        sen_fs0 = 1'b1;
        wait_cyc(10);
        model[0] = 22'd0;
        check_words("R8");
        check("R7", 32'(op_mode), 32'd0);
        // R9: fs1 toggling leaves words alone
        fs1 = ~fs1;
        wait_cyc(8);
        check_words("R9");
        check("R6", 32'(prog_mode), 32'd1);

        // R3: extra leading bits are dropped
        send_word({2'b01, 22'h2A5A5A}, 7);
        check_words("R3");
        send_word({2'b00, 22'h000400}, 3);
        check_words("R4");
        check("R7", 32'(op_mode), 32'd1);

        // Random words to random addresses
        for (int n = 0; n < 36; n++) begin
            logic [23:0] w;
            w = 24'($urandom);
            send_word(w, int'($urandom_range(0, 6)));
            check_words("R5");
            check("R7", 32'(op_mode), 32'(model[0][11:10]));
        end

        // Channel 0 strap has enable low: a rising edge enters and loads nothing
        do_reset(0);
        load_defaults(0);
        sen_fs0 = 1'b1;
        wait_cyc(8);
        check("R6", 32'(prog_mode), 32'd1);
        check_words("R6");
        send_word({2'b11, 22'h1FFFFF}, 0);
        check_words("R4");
        send_word({2'b10, 22'h000001}, 1);
        check_words("R5");
        // R7: pin levels no longer set the mode
        sclk_re = 1'b1;
        sdat_te = 1'b1;
        wait_cyc(6);
        check("R7", 32'(op_mode), 32'(model[0][11:10]));

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule